// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire control link: serial clock, active-low select, and one data line shared by both directions. Behind the link sits a bank of sixteen 8-bit configuration registers. Each frame is 16 bits long and is sent most significant bit first. The upper three bits hold an opcode, the next four hold a register index, one turnaround bit follows, and the low byte carries the data. A write frame stores its byte in the indexed register. A read frame turns the shared line around, and the block shifts the indexed register back to the master.

All three pins are sampled by the chip's system clock through a synchronizer, and edges of the serial clock are found from the sampled stream. For that reason, each serial clock phase must last at least SYNC+2 system clock cycles. The data pad is driven from `sdio_out` under `sdio_oe`, and its input side feeds `sdio_in`. The whole bank is brought out as a flat bus for the logic the registers control. Frames may be chained back to back with select held low. Raising select part way through a frame abandons that frame.

Top module: `sercfg_slave`

## Requirements
- R1: After reset every register reads 8'h00 on `regs_flat` (register n on bits 8n+7..8n) and `sdio_oe` is low.
- R2: A frame with opcode 3'b111 (frame bits 15..13) stores frame bits 7..0 into the register indexed by frame bits 12..9, on the 16th rising serial clock edge.
- R3: A frame with opcode 3'b110 raises `sdio_oe` on the 8th falling serial clock edge. It then presents the indexed register on `sdio_out`, bit 7 first, one bit per falling edge, so the master can sample bits 7..0 on rising edges 9..16.
- R4: After a complete read frame, `sdio_oe` returns low on the 16th falling edge.
- R5: Any opcode other than 3'b110 or 3'b111 leaves every register unchanged and never raises `sdio_oe`.
- R6: If select rises before the 16th rising edge, the write is dropped and no register changes.
- R7: If select rises after the 16th rising edge but before the 16th falling edge, the write already done is kept.
- R8: Select high forces `sdio_oe` low within SYNC+1 system clocks and clears the bit counter. A read cut short in this way releases the line at once.
- R9: With select held low, each further group of 16 serial clocks forms a new, independent frame.
- R10: Counting always restarts at the first rising edge after select falls, so a partial frame followed by a select pulse does not misalign the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Input side of the shared data pad |
| sdio_out | output | 1 | Output side of the shared data pad |
| sdio_oe | output | 1 | Drive enable for the data pad |
| regs_flat | output | 128 | Register bank, register n on bits 8n+7..8n |

## Verification
The assertions check a set of rules on every cycle. The bank changes only on a 16th rising edge seen while select is low. The pad driver switches on only at the 8th falling edge. It switches off only on a falling edge that ends a frame or while select is high. A high select keeps the counter at zero and the pad released. The bench scenarios are the only place where values and orderings are shown. These cover the bit order of read data, round trips from write to read, chained frames, and the two cancellation windows around the 16th clock.

// File: rtl/sercfg_slave.sv
module sercfg_slave #(
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         sdio_in,
  output logic         sdio_out,
  output logic         sdio_oe,
  output logic [127:0] regs_flat
);
  localparam int DW    = 8;
  localparam int NREG  = 16;
  localparam int FLEN  = 16;
  localparam int CW    = $clog2(FLEN);
  localparam logic [2:0] OP_RD = 3'b110;
  localparam logic [2:0] OP_WR = 3'b111;

  logic [2:0] sy [SYNC];
  logic s_sclk, s_cs, s_din, p_sclk;
  logic sclk_rise, sclk_fall;
  logic [CW-1:0]   cnt;
  logic [FLEN-1:0] shreg, nxt;
  logic            rd_pend;
  logic [DW-1:0]   rd_sh;
  logic [DW-1:0]   regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sy[i] <= 3'b010;
    end else begin
      sy[0] <= {sclk, cs_n, sdio_in};
      for (int i = 1; i < SYNC; i++) sy[i] <= sy[i-1];
    end
  end

  assign s_sclk    = sy[SYNC-1][2];
  assign s_cs      = sy[SYNC-1][1];
  assign s_din     = sy[SYNC-1][0];
  assign sclk_rise = s_sclk & ~p_sclk;
  assign sclk_fall = ~s_sclk & p_sclk;
  assign nxt       = {shreg[FLEN-2:0], s_din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sclk   <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      rd_pend  <= 1'b0;
      rd_sh    <= '0;
      sdio_oe  <= 1'b0;
      sdio_out <= 1'b0;
    end else begin
      p_sclk <= s_sclk;
      if (s_cs) begin
        cnt      <= '0;
        rd_pend  <= 1'b0;
        sdio_oe  <= 1'b0;
        sdio_out <= 1'b0;
      end else begin
        if (sclk_rise) begin
          shreg <= nxt;
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(7)) begin
            rd_pend <= (nxt[7:5] == OP_RD);
            rd_sh   <= regs[nxt[4:1]];
          end
        end
        if (sclk_fall) begin
          if (rd_pend && cnt >= CW'(8)) begin
            sdio_oe  <= 1'b1;
            sdio_out <= rd_sh[DW-1];
            rd_sh    <= rd_sh << 1;
          end else if (cnt == '0) begin
            sdio_oe  <= 1'b0;
            sdio_out <= 1'b0;
            rd_pend  <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (!s_cs && sclk_rise && cnt == CW'(FLEN-1) && nxt[15:13] == OP_WR) begin
      regs[nxt[12:9]] <= nxt[7:0];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = regs[g];
  end
endmodule

module sercfg_slave_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         s_cs,
  input logic         sclk_rise,
  input logic         sclk_fall,
  input logic [3:0]   cnt,
  input logic         sdio_oe,
  input logic [127:0] regs_flat
);
  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> ($past(sclk_rise) && $past(cnt) == 4'd15 && !$past(s_cs)));

  assert_oe_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> ($past(sclk_fall) && $past(cnt) == 4'd8 && !$past(s_cs)));

  assert_oe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdio_oe) |-> ($past(s_cs) || ($past(sclk_fall) && $past(cnt) == 4'd0)));

  assert_cs_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> (!sdio_oe && cnt == 4'd0));
endmodule

bind sercfg_slave sercfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_cs(s_cs), .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall), .cnt(cnt), .sdio_oe(sdio_oe), .regs_flat(regs_flat)
);

// File: tb/sercfg_slave_tb.sv
module sercfg_slave_tb_top;
  localparam int HALF = 8;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, din = 0;
  logic dout, oe;
  logic [127:0] regs_flat;
  logic [7:0] expv [16];
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  sercfg_slave dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdio_in(din), .sdio_out(dout), .sdio_oe(oe), .regs_flat(regs_flat));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d);
    return {op, a, 1'b0, d};
  endfunction

  task automatic cs_lo(); cs_n = 0; tick(HALF); endtask
  task automatic cs_hi(); tick(HALF); cs_n = 1; tick(HALF); endtask

  task automatic shift(input logic [15:0] f, input int nrise, input bit last_fall,
                       output logic [7:0] rd, output int oe_hi);
    rd = 0; oe_hi = 0;
    for (int i = 0; i < nrise; i++) begin
      din = f[15-i];
      tick(HALF);
      if (i >= 8) begin rd = {rd[6:0], dout}; if (oe) oe_hi++; end
      sclk = 1;
      tick(HALF);
      if (i < nrise - 1 || last_fall) sclk = 0;
    end
  endtask

  task automatic check_bank(input string req);
    for (int a = 0; a < 16; a++) check(req, int'(regs_flat[a*8 +: 8]), int'(expv[a]));
  endtask

  task automatic t_reset();
    for (int a = 0; a < 16; a++) expv[a] = 8'h00;
    check_bank("R1");
    check("R1 oe", int'(oe), 0);
  endtask

  task automatic t_write_read();
    logic [7:0] rd; int h;
    cs_lo(); shift(mk(3'b111, 4'd3, 8'hA5), 16, 1, rd, h); cs_hi();
    expv[3] = 8'hA5; check_bank("R2");
    cs_lo(); shift(mk(3'b110, 4'd3, 8'h00), 16, 1, rd, h);
    check("R3 data", int'(rd), 8'hA5);
    check("R3 oe cycles", h, 8);
    tick(HALF);
    check("R4 release", int'(oe), 0);
    cs_hi();
  endtask

  task automatic t_all_addr();
    logic [7:0] rd; int h;
    for (int a = 0; a < 16; a++) begin
      cs_lo(); shift(mk(3'b111, 4'(a), 8'(8'h11 * a ^ 8'h3C)), 16, 1, rd, h); cs_hi();
      expv[a] = 8'(8'h11 * a ^ 8'h3C);
    end
    check_bank("R2 all");
    for (int a = 0; a < 16; a += 5) begin
      cs_lo(); shift(mk(3'b110, 4'(a), 8'hFF), 16, 1, rd, h); cs_hi();
      check("R3 readback", int'(rd), int'(expv[a]));
    end
  endtask

  task automatic t_invalid();
    logic [7:0] rd; int h;
    logic [2:0] ops [5] = '{3'b000, 3'b101, 3'b100, 3'b011, 3'b010};
    for (int k = 0; k < 5; k++) begin
      cs_lo(); shift(mk(ops[k], 4'd5, 8'hFF), 16, 1, rd, h); cs_hi();
      check("R5 no drive", h, 0);
    end
    check_bank("R5 bank");
  endtask

  task automatic t_cancel_write();
    logic [7:0] rd; int h;
    cs_lo(); shift(mk(3'b111, 4'd7, 8'h5A), 15, 1, rd, h); cs_n = 1; tick(HALF);
    cs_lo(); shift(mk(3'b111, 4'd7, 8'hC3), 15, 0, rd, h); cs_n = 1; tick(HALF); sclk = 0; tick(HALF);
    check_bank("R6");
  endtask

  task automatic t_late_cs_write();
    logic [7:0] rd; int h;
    cs_lo(); shift(mk(3'b111, 4'd9, 8'h96), 16, 0, rd, h);
    cs_n = 1; tick(HALF); sclk = 0; tick(HALF);
    expv[9] = 8'h96; check_bank("R7");
  endtask

  task automatic t_cancel_read();
    logic [7:0] rd; int h;
    cs_lo(); shift(mk(3'b110, 4'd9, 8'h00), 16, 0, rd, h);
    check("R8 oe before cancel", int'(oe), 1);
    check("R8 data", int'(rd), 8'h96);
    cs_n = 1; tick(4);
    check("R8 oe after cancel", int'(oe), 0);
    sclk = 0; tick(HALF);
    cs_lo(); shift(mk(3'b110, 4'd9, 8'h00), 12, 1, rd, h);
    check("R8 mid drive", int'(oe), 1);
    cs_n = 1; tick(4);
    check("R8 mid release", int'(oe), 0);
    tick(HALF);
  endtask

  task automatic t_chain();
    logic [7:0] rd; int h;
    cs_lo();
    shift(mk(3'b111, 4'd1, 8'h12), 16, 1, rd, h);
    shift(mk(3'b111, 4'd14, 8'hE7), 16, 1, rd, h);
    shift(mk(3'b110, 4'd1, 8'h00), 16, 1, rd, h);
    check("R9 read a", int'(rd), 8'h12);
    shift(mk(3'b110, 4'd14, 8'h00), 16, 1, rd, h);
    check("R9 read b", int'(rd), 8'hE7);
    shift(mk(3'b111, 4'd14, 8'h4B), 16, 1, rd, h);
    cs_hi();
    expv[1] = 8'h12; expv[14] = 8'h4B;
    check_bank("R9 bank");
  endtask

  task automatic t_resync();
    logic [7:0] rd; int h;
    cs_lo(); shift(16'hFFFF, 5, 1, rd, h); cs_n = 1; tick(HALF);
    cs_lo(); shift(mk(3'b111, 4'd0, 8'h81), 16, 1, rd, h); cs_hi();
    expv[0] = 8'h81; check_bank("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(5); rst_n = 1; tick(5);
    t_reset();
    t_write_read();
    t_all_addr();
    t_invalid();
    t_cancel_write();
    t_late_cs_write();
    t_cancel_read();
    t_chain();
    t_resync();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule